// File: doc/BRIEF.md
# Serial Interface Mode Arbiter

This block decides which of two protocol engines, a two-wire I2C target or an SPI target, owns the shared host pins of a sensor interface device. It watches the active-low chip-select line and the serial clock. Both pass through two-flop synchronizers into the system clock domain before any decision is made. While chip-select is high, which is also its idle level because of its pull-up, the I2C engine is enabled. While chip-select is low, the SPI engine is enabled.

A sticky lock protects against a false decode. When the device shares a bus with other SPI targets, their traffic could look like I2C start and stop conditions. So once a set number of serial clock rising edges (four by default) arrive during a single low period of chip-select, the block latches into SPI mode. It stays there whatever chip-select does until the next power-on reset. If chip-select returns high before that count is reached, the count starts again from zero.

For three-wire SPI, a data-pin direction output is raised only during the read-data phase that the SPI engine reports. In four-wire SPI it stays low. The three-wire selection bit comes from a configuration register that resets to 0, so four-wire SPI is the default.

Top module: `sif_mode_arbiter`

## Requirements
- R1: In the cycle after a synchronous power-on reset: `i2c_en`=1, `spi_en`=0, `spi_locked`=0 and `sdio_oe`=0.
- R2: Exactly one of `i2c_en` and `spi_en` is 1 at all times.
- R3: While unlocked, `cs_n`=0 gives `spi_en`=1 and `cs_n`=1 gives `i2c_en`=1, each within three clock cycles of the pin change.
- R4: `spi_locked` becomes 1 after the LOCK_PULSES-th rising edge of `sclk` (default 4) within one low period of `cs_n`, and not after fewer edges.
- R5: Once `spi_locked`=1, it stays 1 and `spi_en` stays 1 whatever `cs_n` and `sclk` do, until `por` is asserted.
- R6: A return of `cs_n` to 1 before the lock is reached clears the edge count, so edges from separate low periods of `cs_n` never add up to a lock.
- R7: Rising edges of `sclk` while `cs_n`=1 are not counted toward the lock.
- R8: `sdio_oe`=1 exactly when `spi_en`=1, `cfg_3wire`=1 (three-wire SPI) and `rd_phase`=1. With `cfg_3wire`=0 (four-wire, the reset default of the register), `sdio_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| cs_n | input | 1 | Chip-select pin, active low, asynchronous |
| sclk | input | 1 | Serial clock pin, asynchronous |
| cfg_3wire | input | 1 | 1 selects three-wire SPI, 0 selects four-wire SPI |
| rd_phase | input | 1 | From the SPI engine: a read-data phase is under way |
| i2c_en | output | 1 | Enables the I2C engine |
| spi_en | output | 1 | Enables the SPI engine |
| spi_locked | output | 1 | Sticky SPI lock flag |
| sdio_oe | output | 1 | Drive enable for the shared data pin in three-wire SPI |

## Verification
The lock logic is tried with four patterns of chip-select and clock. Three edges in one low period are applied without a lock, which separates the threshold from an off-by-one. Three edges, a high period and then three more are applied, which shows whether the count clears or accumulates. Edges are applied with chip-select high, which shows whether they are wrongly counted. The full run of four edges is followed by chip-select high and more clock edges, which shows whether the lock is sticky and stays put once it is saturated. The direction output is stepped through the combinations of configuration bit, read phase and selected engine, so that each gating term is exercised.

// File: rtl/sif_arb_pkg.sv
package sif_arb_pkg;

    // Minimum SCLK rising edges with CS low that force the SPI lock.
    localparam int unsigned LOCK_PULSES_DEF = 4;

    typedef enum logic {
        SEL_I2C = 1'b0,
        SEL_SPI = 1'b1
    } bus_sel_e;

    // Synchronized copy of the host pins.
    typedef struct packed {
        logic cs_n;
        logic sclk;
    } host_pins_s;

    // Idle levels: chip-select pulled high, clock low.
    localparam host_pins_s PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0};

    function automatic bus_sel_e pick_bus(input logic cs_n_s, input logic locked);
        return (locked || !cs_n_s) ? SEL_SPI : SEL_I2C;
    endfunction

endpackage

// File: rtl/sif_sync2.sv
module sif_sync2 #(
    parameter int unsigned        W       = 1,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/sif_lock_counter.sv
module sif_lock_counter #(
    parameter int unsigned LOCK_PULSES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_active,
    input  logic sclk_rise,
    output logic locked
);
    localparam int unsigned   CNT_W = $clog2(LOCK_PULSES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_PULSES - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LOCK_PULSES);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            locked <= 1'b0;
        end else if (locked) begin
            cnt_q  <= cnt_q;               // saturated
        end else if (!cs_active) begin
            cnt_q  <= '0;
        end else if (sclk_rise) begin
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == CNT_LAST) begin
                locked <= 1'b1;
            end
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked); // R5

    AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (rst)
        locked |-> (cnt_q == CNT_FULL)); // R5

    AST_CNT_CLEAR_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && !locked) |=> (cnt_q == '0)); // R6

    AST_LOCK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(sclk_rise) && $past(cs_active))); // R4
endmodule

// File: rtl/sif_dir_ctrl.sv
module sif_dir_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic spi_sel,
    input  logic cfg_3wire,
    input  logic rd_phase,
    output logic sdio_oe
);
    always_comb begin
        sdio_oe = spi_sel && cfg_3wire && rd_phase;
    end

    AST_OE_NOT_FOURWIRE: assert property (@(posedge clk) disable iff (rst)
        !cfg_3wire |-> !sdio_oe); // R8
endmodule

// File: rtl/sif_mode_arbiter.sv
module sif_mode_arbiter
    import sif_arb_pkg::*;
#(
    parameter int unsigned LOCK_PULSES = LOCK_PULSES_DEF
) (
    input  logic clk,
    input  logic por,
    input  logic cs_n,
    input  logic sclk,
    input  logic cfg_3wire,
    input  logic rd_phase,
    output logic i2c_en,
    output logic spi_en,
    output logic spi_locked,
    output logic sdio_oe
);
    host_pins_s pins_raw;
    host_pins_s pins_s;
    logic       sclk_prev_q;
    logic       sclk_rise;
    bus_sel_e   bus_sel;

    assign pins_raw = '{cs_n: cs_n, sclk: sclk};

    sif_sync2 #(
        .W       ($bits(host_pins_s)),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst     (por),
        .d_async (pins_raw),
        .q_sync  (pins_s)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            sclk_prev_q <= PINS_IDLE.sclk;
        end else begin
            sclk_prev_q <= pins_s.sclk;
        end
    end

    assign sclk_rise = pins_s.sclk && !sclk_prev_q;

    sif_lock_counter #(
        .LOCK_PULSES (LOCK_PULSES)
    ) u_lock (
        .clk       (clk),
        .rst       (por),
        .cs_active (!pins_s.cs_n),
        .sclk_rise (sclk_rise),
        .locked    (spi_locked)
    );

    assign bus_sel = pick_bus(pins_s.cs_n, spi_locked);
    assign spi_en  = (bus_sel == SEL_SPI);
    assign i2c_en  = (bus_sel == SEL_I2C);

    sif_dir_ctrl u_dir (
        .clk       (clk),
        .rst       (por),
        .spi_sel   (spi_en),
        .cfg_3wire (cfg_3wire),
        .rd_phase  (rd_phase),
        .sdio_oe   (sdio_oe)
    );

    AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (por)
        $countones({i2c_en, spi_en}) == 1); // R2

    AST_LOCK_HOLDS_SPI: assert property (@(posedge clk) disable iff (por)
        spi_locked |-> spi_en); // R5

    AST_NO_OE_IN_I2C: assert property (@(posedge clk) disable iff (por)
        i2c_en |-> !sdio_oe); // R8
endmodule

// File: tb/test_sif_mode_arbiter.sv
module test_sif_mode_arbiter;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic cfg_3wire = 1'b0;
    logic rd_phase = 1'b0;
    logic i2c_en, spi_en, spi_locked, sdio_oe;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sif_mode_arbiter i_sif_mode_arbiter (
        .clk        (clk),
        .por        (por),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .cfg_3wire  (cfg_3wire),
        .rd_phase   (rd_phase),
        .i2c_en     (i2c_en),
        .spi_en     (spi_en),
        .spi_locked (spi_locked),
        .sdio_oe    (sdio_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk);
        por = 1'b1;
        cs_n = 1'b1; sclk = 1'b0; rd_phase = 1'b0; cfg_3wire = 1'b0;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b1; settle();
            sclk = 1'b0; settle();
        end
    endtask

    task automatic t_reset();
        do_por();
        chk("R1", "i2c_en", i2c_en, 1'b1);
        chk("R1", "spi_en", spi_en, 1'b0);
        chk("R1", "spi_locked", spi_locked, 1'b0);
        chk("R1", "sdio_oe", sdio_oe, 1'b0);
    endtask

    task automatic t_select();
        do_por();
        cs_n = 1'b0; repeat (3) @(negedge clk);
        chk("R3", "spi_en on cs low", spi_en, 1'b1);
        chk("R2", "i2c_en on cs low", i2c_en, 1'b0);
        cs_n = 1'b1; repeat (3) @(negedge clk);
        chk("R3", "i2c_en on cs high", i2c_en, 1'b1);
        chk("R2", "spi_en on cs high", spi_en, 1'b0);
    endtask

    task automatic t_threshold();
        do_por();
        cs_n = 1'b0; settle();
        pulses(3);
        chk("R4", "no lock after 3 edges", spi_locked, 1'b0);
        pulses(1);
        chk("R4", "lock after 4th edge", spi_locked, 1'b1);
    endtask

    task automatic t_sticky();
        // continues from a locked state
        cs_n = 1'b1; settle();
        chk("R5", "lock held with cs high", spi_locked, 1'b1);
        chk("R5", "spi_en held with cs high", spi_en, 1'b1);
        chk("R5", "i2c_en off when locked", i2c_en, 1'b0);
        pulses(5);
        cs_n = 1'b0; pulses(2); cs_n = 1'b1; settle();
        chk("R5", "lock after more edges", spi_locked, 1'b1);
        chk("R5", "spi_en after more edges", spi_en, 1'b1);
        do_por();
        chk("R5", "por clears lock", spi_locked, 1'b0);
        chk("R5", "i2c back after por", i2c_en, 1'b1);
    endtask

    task automatic t_count_clear();
        do_por();
        cs_n = 1'b0; settle(); pulses(3);
        cs_n = 1'b1; settle();
        chk("R6", "i2c after early release", i2c_en, 1'b1);
        cs_n = 1'b0; settle(); pulses(3);
        chk("R6", "no lock from split edges", spi_locked, 1'b0);
        cs_n = 1'b1; settle();
        chk("R6", "i2c after second release", i2c_en, 1'b1);
    endtask

    task automatic t_edges_cs_high();
        do_por();
        pulses(6);
        chk("R7", "no lock with cs high", spi_locked, 1'b0);
        chk("R7", "i2c kept with cs high", i2c_en, 1'b1);
        cs_n = 1'b0; settle(); pulses(3);
        chk("R7", "earlier edges not counted", spi_locked, 1'b0);
        cs_n = 1'b1; settle();
    endtask

    task automatic t_direction();
        do_por();
        cs_n = 1'b0; settle();
        cfg_3wire = 1'b1; rd_phase = 1'b1; #1;
        chk("R8", "oe 3-wire read", sdio_oe, 1'b1);
        rd_phase = 1'b0; #1;
        chk("R8", "oe 3-wire no read", sdio_oe, 1'b0);
        cfg_3wire = 1'b0; rd_phase = 1'b1; #1;
        chk("R8", "oe 4-wire read", sdio_oe, 1'b0);
        cfg_3wire = 1'b1; cs_n = 1'b1; settle();
        chk("R8", "oe in i2c mode", sdio_oe, 1'b0);
        rd_phase = 1'b0; cfg_3wire = 1'b0;
    endtask

    initial begin
        t_reset();
        t_select();
        t_threshold();
        t_sticky();
        t_count_clear();
        t_edges_cs_high();
        t_direction();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule